// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel that sits beside a shared free-running or period-limited timer counter. The counter value and a one-cycle "period reached" pulse come in from outside; the channel holds a single value register that acts as the compare threshold in compare mode and as the capture latch in capture mode. A control word, written and read back over a simple register port, selects the mode, the capture source and edge, an optional input synchronizer, the output pin action, and holds the interrupt enable, the pending flag, a capture-overflow bit and a read-only copy of the input level seen at the last capture.

In compare mode the channel raises its flag once each time the counter arrives at the stored value, and drives its output pin through one of eight actions. The two-action modes apply their first action on the compare hit and their second on the period event. In capture mode a chosen edge of a chosen source copies the counter into the value register and raises the flag. A second capture that arrives before software has cleared the flag marks an overflow. Vectoring between several channels is left to the surrounding logic; this channel only offers a masked interrupt line.

Top module: `cc_channel`

## Requirements
- R1: While reset is held, the control readback, the value register, the output pin and the interrupt line are all zero.
- R2: The control word layout is: bit 0 mode (0 compare, 1 capture), bits 2:1 edge, bits 4:3 source, bit 5 synchronizer enable, bits 8:6 output action, bit 9 software pin level, bit 10 interrupt enable, bit 11 pending flag, bit 12 overflow, bit 13 latched input (read-only), bits 15:14 read as zero. In compare mode the flag is set at the clock edge where the counter equals the value register and did not equal it at the previous edge.
- R3: In capture mode, a capture event copies the counter value seen at that clock edge into the value register and sets the flag. Edge field encoding: 00 no capture, 01 rising, 10 falling, 11 both.
- R4: Source field encoding: 00 input A, 01 input B, 10 constant low, 11 constant high. Transitions on an unselected input cause no capture and leave the flag and value register unchanged.
- R5: With the synchronizer disabled, a capture happens at the first clock edge that samples the new input level; with it enabled, the capture happens two clock edges later.
- R6: Bit 13 holds the selected input level at the most recent capture (1 after a rising capture, 0 after a falling one).
- R7: The overflow bit is set when a capture occurs while the flag is already set; it stays set until software writes it to zero.
- R8: The interrupt line is high exactly when both the flag and the interrupt enable are set.
- R9: A control write loads all writable fields, including clearing or setting the flag and overflow bits; a value write loads the value register. A hardware flag or overflow set in the same cycle as a control write wins over the written value.
- R10: Output actions 000 (pin follows bit 9), 001 (set on hit), 100 (toggle on hit) and 101 (clear on hit) take effect at the clock edge of the compare hit.
- R11: Output actions 010 (toggle/clear), 011 (set/clear), 110 (toggle/set) and 111 (clear/set) apply the first action on a compare hit and the second on the period event.
- R12: When a compare hit and a period event coincide, the period-event action is applied after the compare action, so it decides the final pin level in the two-action modes.
- R13: While the counter stays equal to the value register the flag is set only once, so clearing it does not bring it back until the counter leaves and returns; in capture mode a counter match sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | Shared timer counter value |
| period_i | input | 1 | One-cycle pulse when the shared counter completes its period |
| in_a_i | input | 1 | Capture source A |
| in_b_i | input | 1 | Capture source B |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 16 | Control word write data |
| val_we_i | input | 1 | Value register write strobe |
| val_wdata_i | input | CNT_W | Value register write data |
| ctl_o | output | 16 | Control word readback |
| val_o | output | CNT_W | Value register readback |
| irq_o | output | 1 | Masked interrupt request |
| pin_o | output | 1 | Output pin driven by the action generator |

## Verification
The bench sweeps every combination of edge, source and synchronizer setting with one pulse on input A, so a wrong source decode shows as a capture from a dead input, a swapped edge shows as the wrong captured count or latched level, and a missing synchronizer delay shows as a capture value two counts early. Both-edge captures are what expose an overflow bit that fails to set or that sets on the first capture. All eight output actions are driven through hit, period, hit and a coincident hit-plus-period, which catches a toggle that applies twice, a swapped first and second action, and the wrong winner on coincidence. The counter is also held on the match value after the flag is cleared, which a level-sensitive comparator would fail by re-raising the flag.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int CTL_W = 16;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_e;

    typedef enum logic [1:0] {
        SRC_A    = 2'b00,
        SRC_B    = 2'b01,
        SRC_LOW  = 2'b10,
        SRC_HIGH = 2'b11
    } src_e;

    typedef enum logic [2:0] {
        OM_BIT     = 3'b000,
        OM_SET     = 3'b001,
        OM_TGL_RST = 3'b010,
        OM_SET_RST = 3'b011,
        OM_TGL     = 3'b100,
        OM_RST     = 3'b101,
        OM_TGL_SET = 3'b110,
        OM_RST_SET = 3'b111
    } omode_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_SET,
        ACT_CLR,
        ACT_TGL
    } act_e;

    // Control word, MSB first: bit 0 is cap_mode, bit 15 the top reserved bit.
    typedef struct packed {
        logic [1:0] rsvd;
        logic       lat_in;
        logic       ovf;
        logic       flag;
        logic       irq_en;
        logic       out_bit;
        omode_e     out_mode;
        logic       sync_en;
        src_e       src;
        edge_e      edge_sel;
        logic       cap_mode;
    } ctl_t;

    function automatic act_e hit_action(omode_e m);
        case (m)
            OM_SET, OM_SET_RST:                 return ACT_SET;
            OM_TGL, OM_TGL_RST, OM_TGL_SET:     return ACT_TGL;
            OM_RST, OM_RST_SET:                 return ACT_CLR;
            default:                            return ACT_NONE;
        endcase
    endfunction

    function automatic act_e wrap_action(omode_e m);
        case (m)
            OM_TGL_RST, OM_SET_RST:             return ACT_CLR;
            OM_TGL_SET, OM_RST_SET:             return ACT_SET;
            default:                            return ACT_NONE;
        endcase
    endfunction

    function automatic logic apply_act(act_e a, logic lvl);
        case (a)
            ACT_SET: return 1'b1;
            ACT_CLR: return 1'b0;
            ACT_TGL: return ~lvl;
            default: return lvl;
        endcase
    endfunction

endpackage

// File: rtl/cc_src_sel.sv
module cc_src_sel
    import cc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic in_a_i,
    input  logic in_b_i,
    input  src_e src_i,
    input  logic sync_en_i,
    output logic cur_o,
    output logic prev_o
);

    logic sel;
    logic raw_prev;
    logic sync_out;
    logic sync_prev;

    always_comb begin
        case (src_i)
            SRC_A:   sel = in_a_i;
            SRC_B:   sel = in_b_i;
            SRC_LOW: sel = 1'b0;
            default: sel = 1'b1;
        endcase
    end

    generate
        if (SYNC_STAGES == 1) begin : g_one
            logic stage_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) stage_q <= 1'b0;
                else       stage_q <= sel;
            end
            assign sync_out = stage_q;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] chain_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= {chain_q[SYNC_STAGES-2:0], sel};
            end
            assign sync_out = chain_q[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            raw_prev  <= 1'b0;
            sync_prev <= 1'b0;
        end else begin
            raw_prev  <= sel;
            sync_prev <= sync_out;
        end
    end

    assign cur_o  = sync_en_i ? sync_out  : sel;
    assign prev_o = sync_en_i ? sync_prev : raw_prev;

endmodule

// File: rtl/cc_edge_det.sv
module cc_edge_det
    import cc_pkg::*;
(
    input  logic  cur_i,
    input  logic  prev_i,
    input  edge_e edge_i,
    output logic  ev_o
);

    logic rise;
    logic fall;

    assign rise = cur_i & ~prev_i;
    assign fall = ~cur_i & prev_i;

    always_comb begin
        case (edge_i)
            EDGE_RISE: ev_o = rise;
            EDGE_FALL: ev_o = fall;
            EDGE_BOTH: ev_o = rise | fall;
            default:   ev_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cc_out_gen.sv
module cc_out_gen
    import cc_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  omode_e mode_i,
    input  logic   out_bit_i,
    input  logic   en_i,
    input  logic   hit_i,
    input  logic   wrap_i,
    output logic   pin_o
);

    act_e hit_act;
    act_e wrap_act;
    logic after_hit;
    logic pin_d;

    always_comb begin
        hit_act   = hit_i  ? hit_action(mode_i)  : ACT_NONE;
        wrap_act  = wrap_i ? wrap_action(mode_i) : ACT_NONE;
        after_hit = apply_act(hit_act, pin_o);
        if (mode_i == OM_BIT)
            pin_d = out_bit_i;
        else if (en_i)
            pin_d = apply_act(wrap_act, after_hit);
        else
            pin_d = pin_o;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) pin_o <= 1'b0;
        else       pin_o <= pin_d;
    end

    // R10
    bit_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == OM_BIT) |=> (pin_o == $past(out_bit_i)));

    // R11
    set_clr_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && wrap_i && (mode_i == OM_SET_RST)) |=> !pin_o);

    // R12
    clr_set_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && wrap_i && (mode_i == OM_RST_SET)) |=> pin_o);

endmodule

// File: rtl/cc_channel.sv
module cc_channel
    import cc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             period_i,
    input  logic             in_a_i,
    input  logic             in_b_i,
    input  logic             ctl_we_i,
    input  logic [15:0]      ctl_wdata_i,
    input  logic             val_we_i,
    input  logic [CNT_W-1:0] val_wdata_i,
    output logic [15:0]      ctl_o,
    output logic [CNT_W-1:0] val_o,
    output logic             irq_o,
    output logic             pin_o
);

    ctl_t             ctl_q;
    ctl_t             ctl_w;
    logic [CNT_W-1:0] val_q;
    logic             match_q;
    logic             match;
    logic             cur;
    logic             prev;
    logic             edge_ev;
    logic             cap_ev;
    logic             hit_ev;

    assign ctl_w = ctl_t'(ctl_wdata_i);

    cc_src_sel #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_src (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .in_a_i    (in_a_i),
        .in_b_i    (in_b_i),
        .src_i     (ctl_q.src),
        .sync_en_i (ctl_q.sync_en),
        .cur_o     (cur),
        .prev_o    (prev)
    );

    cc_edge_det i_edge (
        .cur_i  (cur),
        .prev_i (prev),
        .edge_i (ctl_q.edge_sel),
        .ev_o   (edge_ev)
    );

    assign match  = (cnt_i == val_q);
    assign hit_ev = !ctl_q.cap_mode && match && !match_q;
    assign cap_ev = ctl_q.cap_mode && edge_ev;

    cc_out_gen i_out (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .mode_i    (ctl_q.out_mode),
        .out_bit_i (ctl_q.out_bit),
        .en_i      (!ctl_q.cap_mode),
        .hit_i     (hit_ev),
        .wrap_i    (period_i),
        .pin_o     (pin_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q   <= '0;
            val_q   <= '0;
            match_q <= 1'b0;
        end else begin
            match_q <= match;
            if (ctl_we_i) begin
                ctl_q      <= ctl_w;
                ctl_q.rsvd <= '0;
                ctl_q.lat_in <= ctl_q.lat_in;
            end
            if (cap_ev) begin
                ctl_q.lat_in <= cur;
                if (ctl_q.flag) ctl_q.ovf <= 1'b1;
            end
            if (cap_ev || hit_ev) ctl_q.flag <= 1'b1;
            if (cap_ev)
                val_q <= cnt_i;
            else if (val_we_i)
                val_q <= val_wdata_i;
        end
    end

    assign ctl_o = ctl_q;
    assign val_o = val_q;
    assign irq_o = ctl_q.flag & ctl_q.irq_en;

    // R2
    hit_sets_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_ev |=> ctl_q.flag);

    // R3
    capture_latch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cap_ev |=> (ctl_q.flag && (val_q == $past(cnt_i))));

    // R7
    ovf_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(ctl_q.ovf) && !$past(ctl_we_i)) |-> ($past(ctl_q.flag) && $past(cap_ev)));

    // R13
    flag_needs_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(ctl_q.flag) && !$past(ctl_we_i) && !$past(ctl_q.cap_mode))
            |-> ($past(cnt_i) == $past(val_q)));

    // R8
    irq_mask_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ctl_q.irq_en) |-> !irq_o);

endmodule

// File: tb/test_cc_channel.sv
module test_cc_channel;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] cnt_i;
    logic         period_i;
    logic         in_a_i;
    logic         in_b_i;
    logic         ctl_we_i;
    logic [15:0]  ctl_wdata_i;
    logic         val_we_i;
    logic [W-1:0] val_wdata_i;
    logic [15:0]  ctl_o;
    logic [W-1:0] val_o;
    logic         irq_o;
    logic         pin_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cc_channel #(.CNT_W(W), .SYNC_STAGES(2)) i_cc_channel (
        .clk_i       (clk),
        .rst_i       (rst),
        .cnt_i       (cnt_i),
        .period_i    (period_i),
        .in_a_i      (in_a_i),
        .in_b_i      (in_b_i),
        .ctl_we_i    (ctl_we_i),
        .ctl_wdata_i (ctl_wdata_i),
        .val_we_i    (val_we_i),
        .val_wdata_i (val_wdata_i),
        .ctl_o       (ctl_o),
        .val_o       (val_o),
        .irq_o       (irq_o),
        .pin_o       (pin_o)
    );

    function automatic logic [15:0] mk(bit cap, int e, int s, bit y, int m,
                                       bit ob, bit ie, bit fl, bit ov);
        logic [15:0] v;
        v = '0;
        v[0]   = cap;
        v[2:1] = e[1:0];
        v[4:3] = s[1:0];
        v[5]   = y;
        v[8:6] = m[2:0];
        v[9]   = ob;
        v[10]  = ie;
        v[11]  = fl;
        v[12]  = ov;
        return v;
    endfunction

    function automatic bit exp_hit(int m, bit p);
        case (m)
            1, 3:    return 1'b1;
            2, 4, 6: return ~p;
            5, 7:    return 1'b0;
            default: return p;
        endcase
    endfunction

    function automatic bit exp_wrap(int m, bit p);
        case (m)
            2, 3:    return 1'b0;
            6, 7:    return 1'b1;
            default: return p;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic stepc();
        cnt_i = cnt_i + 1'b1;
        step();
    endtask

    task automatic wr_ctl(logic [15:0] v);
        ctl_we_i = 1'b1;
        ctl_wdata_i = v;
        step();
        ctl_we_i = 1'b0;
    endtask

    task automatic wr_val(logic [W-1:0] v);
        val_we_i = 1'b1;
        val_wdata_i = v;
        step();
        val_we_i = 1'b0;
    endtask

    initial begin
        rst = 1'b1; cnt_i = '0; period_i = 1'b0; in_a_i = 1'b0; in_b_i = 1'b0;
        ctl_we_i = 1'b0; ctl_wdata_i = '0; val_we_i = 1'b0; val_wdata_i = '0;
        repeat (3) step();
        // R1 reset state
        chk("R1 ctl", ctl_o, 0);
        chk("R1 val", val_o, 0);
        chk("R1 pin", pin_o, 0);
        chk("R1 irq", irq_o, 0);
        rst = 1'b0;
        step();

        // R2 compare hit and R8 interrupt masking
        wr_val(16'd5);
        chk("R9 value write", val_o, 5);
        wr_ctl(mk(0, 0, 0, 0, 0, 0, 1, 0, 0));
        chk("R9 flag cleared by write", ctl_o[11], 0);
        for (int c = 0; c < 8; c++) begin
            cnt_i = c[W-1:0];
            step();
            chk("R2 compare flag", ctl_o[11], (c >= 5));
            chk("R8 irq with enable", irq_o, (c >= 5));
        end
        wr_ctl(mk(0, 0, 0, 0, 0, 0, 0, 1, 0));
        chk("R8 irq masked", irq_o, 0);
        chk("R9 flag set by write", ctl_o[11], 1);

        // R13 counter held on the match value
        cnt_i = 16'd5;
        step();
        wr_ctl(mk(0, 0, 0, 0, 0, 0, 1, 0, 0));
        repeat (3) step();
        chk("R13 no re-raise while held", ctl_o[11], 0);
        cnt_i = 16'd6; step();
        cnt_i = 16'd5; step();
        chk("R13 raise on return", ctl_o[11], 1);
        wr_ctl(mk(1, 0, 0, 0, 0, 0, 0, 0, 0));
        cnt_i = 16'd4; step();
        cnt_i = 16'd5; step();
        chk("R13 no compare in capture mode", ctl_o[11], 0);
        chk("R13 value kept in capture mode", val_o, 5);

        // R3 R4 R5 R6 R7 capture sweep, pulse on input A only
        for (int y = 0; y < 2; y++) begin
            for (int s = 0; s < 4; s++) begin
                for (int e = 0; e < 4; e++) begin
                    logic [W-1:0] rv, fv, v0;
                    int n;
                    bit r, f;
                    in_a_i = 1'b0; in_b_i = 1'b0;
                    wr_ctl(mk(1, e, s, y[0], 0, 0, 0, 0, 0));
                    repeat (5) stepc();
                    wr_ctl(mk(1, e, s, y[0], 0, 0, 0, 0, 0));
                    repeat (5) stepc();
                    v0 = val_o;
                    r = (s == 0) && (e[0] == 1'b1);
                    f = (s == 0) && (e[1] == 1'b1);
                    n = int'(r) + int'(f);
                    rv = cnt_i + 16'd1 + (y ? 16'd2 : 16'd0);
                    in_a_i = 1'b1;
                    repeat (6) stepc();
                    fv = cnt_i + 16'd1 + (y ? 16'd2 : 16'd0);
                    in_a_i = 1'b0;
                    repeat (6) stepc();
                    chk("R3 R4 capture flag", ctl_o[11], (n > 0));
                    chk("R7 overflow", ctl_o[12], (n == 2));
                    if (n == 0) begin
                        chk("R4 value untouched", val_o, v0);
                    end else begin
                        chk("R3 R5 captured count", val_o, f ? fv : rv);
                        chk("R6 latched level", ctl_o[13], f ? 0 : 1);
                    end
                end
            end
        end

        // R4 input B selected and pulsed
        wr_ctl(mk(1, 1, 1, 0, 0, 0, 1, 0, 0));
        repeat (2) stepc();
        begin
            logic [W-1:0] bv;
            bv = cnt_i + 16'd1;
            in_b_i = 1'b1;
            stepc();
            chk("R4 source B capture", val_o, bv);
            chk("R8 irq on capture", irq_o, 1);
            in_b_i = 1'b0;
        end
        // R7 overflow sticky until written to zero
        wr_ctl(mk(1, 3, 1, 0, 0, 0, 0, 1, 1));
        repeat (3) stepc();
        chk("R7 overflow held", ctl_o[12], 1);
        wr_ctl(mk(1, 0, 1, 0, 0, 0, 0, 0, 0));
        chk("R7 overflow cleared", ctl_o[12], 0);

        // R10 R11 R12 output actions
        cnt_i = '0;
        wr_val(16'd10);
        for (int m = 0; m < 8; m++) begin
            bit p;
            cnt_i = '0; period_i = 1'b0;
            wr_ctl(mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
            step(); step();
            chk("R10 pin forced low", pin_o, 0);
            wr_ctl(mk(0, 0, 0, 0, m, (m == 0), 0, 0, 0));
            p = 1'b0;
            cnt_i = 16'd10; step();
            p = (m == 0) ? 1'b1 : exp_hit(m, p);
            chk((m == 0 || m == 1 || m == 4 || m == 5) ? "R10 hit action" : "R11 first action", pin_o, p);
            cnt_i = 16'd11; period_i = 1'b1; step(); period_i = 1'b0;
            p = (m == 0) ? 1'b1 : exp_wrap(m, p);
            chk("R11 period action", pin_o, p);
            cnt_i = 16'd10; step();
            p = (m == 0) ? 1'b1 : exp_hit(m, p);
            chk("R10 R11 second hit", pin_o, p);
            cnt_i = 16'd0; step();
            cnt_i = 16'd10; period_i = 1'b1; step(); period_i = 1'b0;
            p = (m == 0) ? 1'b1 : exp_wrap(m, exp_hit(m, p));
            chk("R12 coincident hit and period", pin_o, p);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule